// File: doc/BRIEF.md
# Coherence directory home controller

This block is the home-node side of a directory-based cache coherence scheme for a small shared-memory multiprocessor. For every memory block it homes, it keeps a directory entry made of a state (uncached, shared or exclusive) and a presence vector with one bit per processor. A small word-addressed memory stands in for main memory. Each block holds one word.

Caches send read misses and write misses on a request channel. They send data write-backs on a separate write-back channel. The controller answers each request with a data reply. When the directory shows other copies, it first sends point-to-point probes (invalidate, fetch, or fetch-and-invalidate), and it sends them only to the processors whose presence bits are set. The controller handles one request at a time. If a request needs the owner's data, the controller holds off all further requests until that owner's write-back arrives.

All channels use a valid/ready handshake. A write-back that arrives with no recall pending is treated as an eviction.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every directory entry is uncached with an empty presence vector and every memory word is zero; a read miss to any block then replies 0 with no probe.
- R2: A read miss (req_wr=0) from processor i on an uncached or shared block replies the memory word without any probe and adds i to the presence vector, with the entry shared.
- R3: A read miss on a block held exclusive by another processor sends one probe of kind fetch (prb_kind=1) to the owner, waits for that owner's write-back to the same block, writes its data to memory, replies that data to i, and leaves the entry shared by the old owner and i.
- R4: A write miss (req_wr=1) from processor i on an uncached or shared block sends an invalidate (prb_kind=0) to every other processor in the presence vector, one per handshake in ascending processor number, never to i, then replies the memory word and makes i the sole exclusive owner.
- R5: A write miss on a block held exclusive by another processor sends one fetch-and-invalidate (prb_kind=2) to the owner, stores the owner's write-back in memory, replies that data and makes i the sole exclusive owner. A write miss from the current owner replies the memory word with no probe.
- R6: A write-back from the exclusive owner with no recall pending writes memory and makes the entry uncached with an empty presence vector, with no probe and no reply.
- R7: A write-back from a processor that is not the exclusive owner of that block changes neither memory nor the directory and produces no output.
- R8: A read miss from the current exclusive owner replies the memory word with no probe and leaves the entry shared with only that processor present.
- R9: req_ready is low while a probe or reply is pending, while a recall waits for its write-back, and in any idle cycle where wb_valid is high, so a write-back is taken before a request that arrives in the same cycle.
- R10: Once prb_valid or rsp_valid is raised, it stays high with the same payload until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Miss request accepted this cycle |
| req_wr | input | 1 | 0 read miss, 1 write miss |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_addr | input | $clog2(NBLK) | Block address |
| wb_valid | input | 1 | Write-back present |
| wb_ready | output | 1 | Write-back accepted this cycle |
| wb_src | input | $clog2(NPROC) | Processor writing back |
| wb_addr | input | $clog2(NBLK) | Block written back |
| wb_data | input | DW | Written-back word |
| prb_valid | output | 1 | Probe present |
| prb_ready | input | 1 | Probe taken by destination |
| prb_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate |
| prb_dest | output | $clog2(NPROC) | Destination processor |
| prb_addr | output | $clog2(NBLK) | Probed block |
| rsp_valid | output | 1 | Data reply present |
| rsp_ready | input | 1 | Reply taken |
| rsp_dest | output | $clog2(NPROC) | Processor receiving the reply |
| rsp_data | output | DW | Reply word |

## Verification
The bench uses four processors and four blocks and runs a long pseudo-random mix of read misses, write misses, owner evictions and stray write-backs against a directory model kept in the bench. Each kind of step is therefore met from uncached, shared-by-many, owned-by-another and owned-by-self entries. The probe sequences seen on the port separate the presence vectors those histories should produce. The reply values are fresh write-back words, so they show whether memory was updated or the stale word was returned. A directed collision between an eviction and a read miss in the same cycle shows that the write-back wins.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    DIR_UNC = 2'd0,
    DIR_SHR = 2'd1,
    DIR_EXC = 2'd2
  } dir_state_e;

  typedef enum logic [1:0] {
    PRB_INV       = 2'd0,
    PRB_FETCH     = 2'd1,
    PRB_FETCH_INV = 2'd2
  } prb_kind_e;

  typedef enum logic [1:0] {
    C_IDLE  = 2'd0,
    C_PROBE = 2'd1,
    C_WAIT  = 2'd2,
    C_REPLY = 2'd3
  } ctl_state_e;

  // index of the lowest set bit among the first n bits, 0 when none
  function automatic int unsigned first_set(input logic [63:0] v, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (i < int'(n) && v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/coh_dir_table.sv
module coh_dir_table
  import coh_dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 4,
  localparam int AW   = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_idx,
  output dir_state_e       rd_state,
  output logic [NPROC-1:0] rd_shr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  dir_state_e       wr_state,
  input  logic [NPROC-1:0] wr_shr
);

  dir_state_e       st_q  [NBLK];
  logic [NPROC-1:0] shr_q [NBLK];

  for (genvar e = 0; e < NBLK; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[e]  <= DIR_UNC;
        shr_q[e] <= '0;
      end else if (wr_en && wr_idx == AW'(e)) begin
        st_q[e]  <= wr_state;
        shr_q[e] <= wr_shr;
      end
    end
  end

  assign rd_state = st_q[rd_idx];
  assign rd_shr   = shr_q[rd_idx];

endmodule

// File: rtl/coh_dir_mem.sv
module coh_dir_mem #(
  parameter int NBLK = 4,
  parameter int DW   = 16,
  localparam int AW  = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] word_q [NBLK];

  for (genvar w = 0; w < NBLK; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                               word_q[w] <= '0;
      else if (wr_en && wr_idx == AW'(w))       word_q[w] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/coh_dir_probe_pick.sv
module coh_dir_probe_pick
  import coh_dir_pkg::*;
#(
  parameter int NPROC = 4,
  localparam int PW   = $clog2(NPROC)
) (
  input  logic [NPROC-1:0] mask,
  output logic             any,
  output logic [PW-1:0]    idx,
  output logic [NPROC-1:0] rest
);

  always_comb begin
    any  = |mask;
    idx  = PW'(first_set(64'(mask), NPROC));
    rest = mask & ~(NPROC'(1) << idx);
  end

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
  import coh_dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 4,
  parameter int DW    = 16,
  localparam int PW   = $clog2(NPROC),
  localparam int AW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_wr,
  input  logic [PW-1:0] req_src,
  input  logic [AW-1:0] req_addr,
  input  logic          wb_valid,
  output logic          wb_ready,
  input  logic [PW-1:0] wb_src,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  output logic          prb_valid,
  input  logic          prb_ready,
  output logic [1:0]    prb_kind,
  output logic [PW-1:0] prb_dest,
  output logic [AW-1:0] prb_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [PW-1:0] rsp_dest,
  output logic [DW-1:0] rsp_data
);

  ctl_state_e       fsm_q;
  logic [AW-1:0]    cur_idx_q;
  logic [PW-1:0]    cur_src_q;
  logic             cur_wr_q;
  logic [PW-1:0]    owner_q;
  logic [NPROC-1:0] pend_q;
  logic             recall_q;
  prb_kind_e        kind_q;
  logic [DW-1:0]    rsp_data_q;

  // directory and memory ports
  logic [AW-1:0]    lk_idx;
  dir_state_e       lk_state;
  logic [NPROC-1:0] lk_shr;
  logic             tbl_we;
  logic [AW-1:0]    tbl_widx;
  dir_state_e       tbl_wstate;
  logic [NPROC-1:0] tbl_wshr;
  logic [DW-1:0]    mem_rdata;
  logic             mem_we;
  logic [AW-1:0]    mem_widx;

  // named events
  logic             req_fire, wb_fire, prb_fire, rsp_fire;
  logic             evt_recall_done, evt_evict, need_recall;
  logic [NPROC-1:0] src_bit, wbsrc_bit, cur_bit, own_bit, inv_mask;
  logic             pick_any;
  logic [PW-1:0]    pick_idx;
  logic [NPROC-1:0] pick_rest;

  coh_dir_table #(.NPROC(NPROC), .NBLK(NBLK)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_state(lk_state), .rd_shr(lk_shr),
    .wr_en(tbl_we), .wr_idx(tbl_widx), .wr_state(tbl_wstate), .wr_shr(tbl_wshr)
  );

  coh_dir_mem #(.NBLK(NBLK), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_data(mem_rdata),
    .wr_en(mem_we), .wr_idx(mem_widx), .wr_data(wb_data)
  );

  coh_dir_probe_pick #(.NPROC(NPROC)) u_pick (
    .mask(pend_q), .any(pick_any), .idx(pick_idx), .rest(pick_rest)
  );

  // handshakes and lookup index
  always_comb begin
    wb_ready  = (fsm_q == C_IDLE) || (fsm_q == C_WAIT);
    req_ready = (fsm_q == C_IDLE) && !wb_valid;
    req_fire  = req_valid && req_ready;
    wb_fire   = wb_valid && wb_ready;
    prb_fire  = prb_valid && prb_ready;
    rsp_fire  = rsp_valid && rsp_ready;

    lk_idx = cur_idx_q;
    if (fsm_q == C_IDLE)               lk_idx = wb_valid ? wb_addr : req_addr;
    else if (fsm_q == C_WAIT && wb_valid) lk_idx = wb_addr;

    src_bit   = NPROC'(1) << req_src;
    wbsrc_bit = NPROC'(1) << wb_src;
    cur_bit   = NPROC'(1) << cur_src_q;
    own_bit   = NPROC'(1) << owner_q;

    need_recall = (lk_state == DIR_EXC) && ((lk_shr & src_bit) == '0);
    inv_mask    = (lk_state == DIR_SHR) ? (lk_shr & ~src_bit) : '0;

    evt_recall_done = wb_fire && (fsm_q == C_WAIT) &&
                      (wb_addr == cur_idx_q) && (wb_src == owner_q);
    evt_evict       = wb_fire && !evt_recall_done &&
                      (lk_state == DIR_EXC) && ((lk_shr & wbsrc_bit) != '0);
  end

  // directory and memory updates
  always_comb begin
    tbl_we     = 1'b0;
    tbl_widx   = lk_idx;
    tbl_wstate = DIR_UNC;
    tbl_wshr   = '0;
    mem_we     = 1'b0;
    mem_widx   = lk_idx;
    if (evt_recall_done) begin
      tbl_we     = 1'b1;
      tbl_widx   = cur_idx_q;
      tbl_wstate = cur_wr_q ? DIR_EXC : DIR_SHR;
      tbl_wshr   = cur_wr_q ? cur_bit : (cur_bit | own_bit);
      mem_we     = 1'b1;
      mem_widx   = cur_idx_q;
    end else if (evt_evict) begin
      tbl_we     = 1'b1;
      tbl_widx   = wb_addr;
      mem_we     = 1'b1;
      mem_widx   = wb_addr;
    end else if (req_fire && !need_recall) begin
      tbl_we     = 1'b1;
      tbl_widx   = req_addr;
      tbl_wstate = req_wr ? DIR_EXC : DIR_SHR;
      if (req_wr || lk_state == DIR_EXC) tbl_wshr = src_bit;
      else                               tbl_wshr = lk_shr | src_bit;
    end
  end

  // control sequence
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q      <= C_IDLE;
      cur_idx_q  <= '0;
      cur_src_q  <= '0;
      cur_wr_q   <= 1'b0;
      owner_q    <= '0;
      pend_q     <= '0;
      recall_q   <= 1'b0;
      kind_q     <= PRB_INV;
      rsp_data_q <= '0;
    end else begin
      case (fsm_q)
        C_IDLE: if (req_fire) begin
          cur_idx_q <= req_addr;
          cur_src_q <= req_src;
          cur_wr_q  <= req_wr;
          owner_q   <= PW'(first_set(64'(lk_shr), NPROC));
          if (need_recall) begin
            pend_q   <= lk_shr;
            kind_q   <= req_wr ? PRB_FETCH_INV : PRB_FETCH;
            recall_q <= 1'b1;
            fsm_q    <= C_PROBE;
          end else begin
            rsp_data_q <= mem_rdata;
            recall_q   <= 1'b0;
            kind_q     <= PRB_INV;
            if (req_wr && inv_mask != '0) begin
              pend_q <= inv_mask;
              fsm_q  <= C_PROBE;
            end else begin
              fsm_q  <= C_REPLY;
            end
          end
        end
        C_PROBE: if (prb_fire) begin
          pend_q <= pick_rest;
          if (pick_rest == '0) fsm_q <= recall_q ? C_WAIT : C_REPLY;
        end
        C_WAIT: if (evt_recall_done) begin
          rsp_data_q <= wb_data;
          fsm_q      <= C_REPLY;
        end
        default: if (rsp_fire) fsm_q <= C_IDLE;
      endcase
    end
  end

  assign prb_valid = (fsm_q == C_PROBE) && pick_any;
  assign prb_kind  = kind_q;
  assign prb_dest  = pick_idx;
  assign prb_addr  = cur_idx_q;
  assign rsp_valid = (fsm_q == C_REPLY);
  assign rsp_dest  = cur_src_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk #(
  parameter int PW = 2,
  parameter int AW = 2,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          wb_valid,
  input logic [DW-1:0] wb_data,
  input logic          prb_valid,
  input logic          prb_ready,
  input logic [1:0]    prb_kind,
  input logic [PW-1:0] prb_dest,
  input logic [AW-1:0] prb_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [PW-1:0] rsp_dest,
  input logic [DW-1:0] rsp_data,
  input logic [PW-1:0] cur_src_q,
  input logic          evt_recall_done,
  input logic          evt_evict
);

  // R9
  probe_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid |-> !req_ready);

  // R9
  reply_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R9
  wb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wb_valid);

  // R10
  probe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid && !prb_ready |=> prb_valid && $stable(prb_dest) && $stable(prb_kind) && $stable(prb_addr));

  // R10
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_dest) && $stable(rsp_data));

  // R4
  no_self_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid && prb_kind == 2'd0 |-> prb_dest != cur_src_q);

  // R3
  recall_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_recall_done |=> rsp_valid && rsp_data == $past(wb_data));

  // R6
  evict_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_evict |=> !rsp_valid && !prb_valid);

endmodule

bind coh_home_dir coh_dir_chk #(.PW(PW), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wb_valid(wb_valid),
  .wb_data(wb_data), .prb_valid(prb_valid), .prb_ready(prb_ready),
  .prb_kind(prb_kind), .prb_dest(prb_dest), .prb_addr(prb_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_dest(rsp_dest),
  .rsp_data(rsp_data), .cur_src_q(cur_src_q),
  .evt_recall_done(evt_recall_done), .evt_evict(evt_evict)
);

// File: tb/test_coh_home_dir.sv
module test_coh_home_dir;

  localparam int NP = 4;
  localparam int NB = 4;
  localparam int DW = 16;
  localparam int UNC = 0, SHR = 1, EXC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_wr = 0;
  logic [1:0] req_src = 0, req_addr = 0;
  logic req_ready;
  logic wb_valid = 0;
  logic [1:0] wb_src = 0, wb_addr = 0;
  logic [DW-1:0] wb_data = 0;
  logic wb_ready;
  logic prb_valid, prb_ready = 0;
  logic [1:0] prb_kind, prb_dest, prb_addr;
  logic rsp_valid, rsp_ready = 0;
  logic [1:0] rsp_dest;
  logic [DW-1:0] rsp_data;

  always #2 clk = ~clk;

  coh_home_dir #(.NPROC(NP), .NBLK(NB), .DW(DW)) i_coh_home_dir (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_src(req_src), .req_addr(req_addr),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_src(wb_src),
    .wb_addr(wb_addr), .wb_data(wb_data),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_kind(prb_kind),
    .prb_dest(prb_dest), .prb_addr(prb_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_dest(rsp_dest),
    .rsp_data(rsp_data)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  // bench-side directory model
  int          ms   [NB];
  logic [3:0]  msh  [NB];
  int          mown [NB];
  logic [15:0] mm   [NB];

  function automatic logic [15:0] next_val();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_req(input bit wr, input int src, input int blk);
    int t = 0;
    req_wr = wr; req_src = 2'(src); req_addr = 2'(blk); req_valid = 1;
    while (!req_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic send_wb(input int src, input int blk, input logic [15:0] d);
    int t = 0;
    wb_src = 2'(src); wb_addr = 2'(blk); wb_data = d; wb_valid = 1;
    while (!wb_ready && t < 100) begin @(negedge clk); t++; end
    @(negedge clk);
    wb_valid = 0;
  endtask

  task automatic get_probe(input int kind, input int dest, input int blk, input string req);
    int t = 0;
    while (!prb_valid && t < 50) begin @(negedge clk); t++; end
    chk(prb_valid, req, "probe present", int'(prb_valid), 1);
    chk(int'(prb_kind) == kind, req, "probe kind", int'(prb_kind), kind);
    chk(int'(prb_dest) == dest, req, "probe dest", int'(prb_dest), dest);
    chk(int'(prb_addr) == blk, req, "probe addr", int'(prb_addr), blk);
    prb_ready = 1;
    @(negedge clk);
    prb_ready = 0;
  endtask

  task automatic get_reply(input int dest, input logic [15:0] d, input string req);
    int t = 0, stray = 0;
    while (!rsp_valid && t < 50) begin
      if (prb_valid) begin
        stray++;
        prb_ready = 1; @(negedge clk); prb_ready = 0;
      end else @(negedge clk);
      t++;
    end
    chk(stray == 0, req, "unexpected probes", stray, 0);
    chk(rsp_valid, req, "reply present", int'(rsp_valid), 1);
    chk(int'(rsp_dest) == dest, req, "reply dest", int'(rsp_dest), dest);
    chk(rsp_data == d, req, "reply data", int'(rsp_data), int'(d));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic op_read(input int src, input int blk);
    logic [15:0] d;
    send_req(0, src, blk);
    if (ms[blk] == EXC && mown[blk] != src) begin
      get_probe(1, mown[blk], blk, "R3");
      chk(!req_ready, "R9", "req_ready during recall", int'(req_ready), 0);
      d = next_val();
      send_wb(mown[blk], blk, d);
      mm[blk] = d;
      get_reply(src, d, "R3");
      msh[blk] = (4'b1 << mown[blk]) | (4'b1 << src);
    end else if (ms[blk] == EXC) begin
      get_reply(src, mm[blk], "R8");
      msh[blk] = 4'b1 << src;
    end else begin
      get_reply(src, mm[blk], "R2");
      msh[blk] = msh[blk] | (4'b1 << src);
    end
    ms[blk] = SHR;
  endtask

  task automatic op_write(input int src, input int blk);
    logic [15:0] d;
    send_req(1, src, blk);
    if (ms[blk] == EXC && mown[blk] != src) begin
      get_probe(2, mown[blk], blk, "R5");
      chk(!req_ready, "R9", "req_ready during recall", int'(req_ready), 0);
      d = next_val();
      send_wb(mown[blk], blk, d);
      mm[blk] = d;
      get_reply(src, d, "R5");
    end else if (ms[blk] == EXC) begin
      get_reply(src, mm[blk], "R5");
    end else begin
      for (int j = 0; j < NP; j++)
        if (msh[blk][j] && j != src) get_probe(0, j, blk, "R4");
      get_reply(src, mm[blk], "R4");
    end
    ms[blk] = EXC; msh[blk] = 4'b1 << src; mown[blk] = src;
  endtask

  task automatic op_evict(input int blk);
    logic [15:0] d;
    if (ms[blk] == EXC) begin
      d = next_val();
      send_wb(mown[blk], blk, d);
      mm[blk] = d; ms[blk] = UNC; msh[blk] = 4'b0;
      chk(!prb_valid && !rsp_valid, "R6", "output after eviction",
          int'({prb_valid, rsp_valid}), 0);
    end
  endtask

  task automatic op_stray(input int src, input int blk);
    int s = src;
    if (ms[blk] == EXC && mown[blk] == s) s = (s + 1) % NP;
    send_wb(s, blk, next_val());
    chk(!prb_valid && !rsp_valid, "R7", "output after stray write-back",
        int'({prb_valid, rsp_valid}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin ms[b] = UNC; msh[b] = 0; mown[b] = 0; mm[b] = 0; end
    repeat (3) @(negedge clk);
    chk(!prb_valid && !rsp_valid, "R1", "outputs in reset", int'({prb_valid, rsp_valid}), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: every block reads zero with no probe
    for (int b = 0; b < NB; b++) op_read(b % NP, b);

    // R4: three sharers, then a write miss invalidates the other two in order
    op_read(3, 1); op_read(0, 1);
    op_write(1, 1);
    // R8: read miss from the owner, then a write from another shows only that reader
    op_write(3, 2); op_read(3, 2); op_write(0, 2);
    // R3 and R5 recalls
    op_read(2, 2); op_write(3, 2); op_write(1, 2);
    // R6 and R7
    op_stray(2, 2); op_read(0, 2); op_write(2, 3); op_evict(3); op_read(1, 3);

    // R9: write-back and request in the same idle cycle, write-back goes first
    op_write(1, 0);
    begin
      logic [15:0] d = next_val();
      wb_src = 2'd1; wb_addr = 2'd0; wb_data = d; wb_valid = 1;
      req_wr = 0; req_src = 2'd2; req_addr = 2'd0; req_valid = 1;
      #1;
      chk(!req_ready, "R9", "req_ready with write-back pending", int'(req_ready), 0);
      @(negedge clk);
      wb_valid = 0;
      mm[0] = d; ms[0] = UNC; msh[0] = 0;
      begin
        int t = 0;
        while (!req_ready && t < 20) begin @(negedge clk); t++; end
      end
      @(negedge clk);
      req_valid = 0;
      get_reply(2, d, "R9");
      ms[0] = SHR; msh[0] = 4'b0100;
    end

    // near-exhaustive pseudo-random mix
    for (int k = 0; k < 600; k++) begin
      logic [15:0] r = next_val();
      int src = int'(r[1:0]);
      int blk = int'(r[3:2]);
      case (int'(r[6:4]) % 5)
        0, 1:    op_read(src, blk);
        2:       op_write(src, blk);
        3:       op_evict(blk);
        default: op_stray(src, blk);
      endcase
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule